// File: doc/BRIEF.md
# Time-Slot HDLC Transmit Controller

This block is the transmit half of a signaling controller for a framed serial line. Each frame has one framing bit followed by 24 eight-bit time slots, 193 bit times in all. Software writes bytes into a 64-entry buffer, and each byte carries an end-of-frame marker. The controller sends the bytes in one of two ways. In HDLC mode it wraps them in flags, appends a 16-bit frame check sequence and inserts zero bits. In transparent mode it sends them as raw bits. Only bit times that fall inside time slots enabled by a 24-bit mask carry controller data.

The bit clock is given as a one-cycle enable, `bit_en`. The frame-sync pulse `fsync` is asserted together with `bit_en` on the framing bit. Each bit the controller places on the line appears on `ser_out`, qualified by a one-cycle `ser_vld` pulse in the cycle after the `bit_en` that carried it.

When no frame is in progress, HDLC mode fills the line with flags or with a programmable idle byte. Transparent mode always fills with the idle byte. A continuous option in transparent mode resends the stored bytes in a loop until software turns it off.

Top module: `slot_hdlc_tx`

## Requirements
- R1: After reset `ser_vld`, `ovf_flag` and `udr_flag` are low, and no bit is marked valid before the first `fsync` has been seen.
- R2: Counting the bit times after the framing bit from 1 to 192, bit time n belongs to slot k=(n-1)/8. `ser_vld` pulses in the cycle after a `bit_en` exactly when that bit time is in slot k with `slot_en[k]`=1. The framing bit never carries data.
- R3: The buffer holds 64 bytes. A write while it holds 64 bytes is dropped and never transmitted, and it sets `ovf_flag`, which stays high until reset.
- R4: In HDLC mode (`cfg_raw`=0), a frame starts at the next byte boundary once the buffer is not empty. It is sent as flag 0x7E, the data bytes in write order, two check bytes, and a closing flag 0x7E. The frame ends with the byte written with `wr_eof`=1. A following frame gets its own opening flag.
- R5: The check sequence is CRC-16 in reflected form (polynomial 0x8408, preset 0xFFFF) over the data bits. It is complemented, and its low byte is sent first.
- R6: Every byte goes out LSB first. In HDLC data and check bytes, a 0 is inserted after five consecutive 1 bits, and the run may span byte boundaries. Flags, fill and abort bytes receive no insertion.
- R7: Between HDLC frames, each timefill byte is 0x7E when `cfg_fill_flag`=1 and `cfg_idle` when `cfg_fill_flag`=0.
- R8: If the buffer is empty when the byte after a non-final data byte is due, the controller sends eight 1 bits (abort), sets `udr_flag` (sticky until reset) and returns to timefill.
- R9: In transparent mode (`cfg_raw`=1), bytes go out unmodified with no flags, check bytes or zero insertion. When the buffer is empty, `cfg_idle` is sent whatever the value of `cfg_fill_flag`.
- R10: In transparent mode with `cfg_cont`=1, the stored bytes are sent repeatedly in write order without being removed. Clearing `cfg_cont` discards them, so idle bytes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to buffer |
| wr_eof | input | 1 | Written byte closes the current frame |
| cfg_raw | input | 1 | 1 = transparent mode, 0 = HDLC mode |
| cfg_cont | input | 1 | Continuous repeat in transparent mode |
| cfg_fill_flag | input | 1 | HDLC timefill: 1 = flags, 0 = idle byte |
| cfg_idle | input | 8 | Programmable idle byte |
| slot_en | input | SLOTS | Time-slot enable mask, bit k for slot k |
| bit_en | input | 1 | Line bit-clock enable, one cycle per bit |
| fsync | input | 1 | Framing-bit marker, valid with `bit_en` |
| ser_out | output | 1 | Serial data bit |
| ser_vld | output | 1 | `ser_out` holds a controller bit |
| ovf_flag | output | 1 | Sticky write-overflow flag |
| udr_flag | output | 1 | Sticky mid-frame underrun flag |

## Verification
The assertions assume three things about the inputs. `fsync` is asserted only together with `bit_en`. Mode and mask inputs change only while the bit clock is paused, with one exception: `cfg_cont` may be cleared at a byte boundary. Under these assumptions, the sticky flags, the overflow response and the rule that valid bits come only after a sync are properties of the design alone.

The stimulus follows the same rules. It loads the buffer and sets the configuration while `bit_en` is idle, and it starts the line clock only afterwards. It stops the clock after an exact count of slot-bearing bits, so a pause always falls on a known byte boundary. Every scenario starts from reset with the position counter set mid-frame, so each one first passes through a stretch of unsynchronised bit times.

// File: rtl/tsh_pkg.sv
`timescale 1ns/1ps
package tsh_pkg;
  localparam int          SLOT_BITS = 8;
  localparam logic [7:0]  FLAG_BYTE = 8'h7E;
  localparam logic [7:0]  ABORT_BYTE = 8'hFF;
  localparam logic [15:0] FCS_POLY  = 16'h8408;
  localparam logic [15:0] FCS_INIT  = 16'hFFFF;
  localparam int          STUFF_RUN = 5;

  typedef enum logic [2:0] {
    ST_FILL, ST_OPEN, ST_DATA, ST_FCS_LO, ST_FCS_HI, ST_CLOSE, ST_ABORT, ST_RAW
  } tx_st_e;
endpackage

// File: rtl/tsh_fifo.sv
`timescale 1ns/1ps
module tsh_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_pop,
  input  logic         cont,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full,
  output logic         wr_drop
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] ONE = (AW+1)'(1);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q, cp_q, wp_n, rp_n, cp_n;
  logic         cont_q;

  assign empty   = (wp_q == rp_q);
  assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign wr_drop = wr_en && full;
  assign rd_data = mem[cont ? cp_q[AW-1:0] : rp_q[AW-1:0]];

  always_comb begin
    wp_n = wp_q;
    rp_n = rp_q;
    cp_n = cp_q;
    if (wr_en && !full) wp_n = wp_q + ONE;
    if (cont_q && !cont)                rp_n = wp_q;   // leaving repeat: drop stored bytes
    else if (rd_pop && !cont && !empty) rp_n = rp_q + ONE;
    if (!cont)                cp_n = rp_n;            // cursor follows read pointer
    else if (rd_pop && !empty) cp_n = ((cp_q + ONE) == wp_q) ? rp_q : (cp_q + ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cp_q   <= '0;
      cont_q <= 1'b0;
    end else begin
      wp_q   <= wp_n;
      rp_q   <= rp_n;
      cp_q   <= cp_n;
      cont_q <= cont;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[wp_q[AW-1:0]] <= wr_data;
  end
endmodule

// File: rtl/tsh_slot_timer.sv
`timescale 1ns/1ps
module tsh_slot_timer #(
  parameter int SLOTS     = 24,
  parameter int SLOT_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             fsync,
  input  logic [SLOTS-1:0] slot_en,
  output logic             take
);
  localparam int SW = $clog2(SLOTS);
  localparam int BW = $clog2(SLOT_BITS);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(SLOT_BITS - 1);

  logic          synced_q, synced_n;
  logic [SW-1:0] slot_q, slot_n;
  logic [BW-1:0] bidx_q, bidx_n;

  assign take = bit_en && !fsync && synced_q && slot_en[slot_q];

  always_comb begin
    synced_n = synced_q;
    slot_n   = slot_q;
    bidx_n   = bidx_q;
    if (bit_en && fsync) begin
      synced_n = 1'b1;
      slot_n   = '0;
      bidx_n   = '0;
    end else if (bit_en && synced_q) begin
      if (bidx_q == BIT_LAST) begin
        bidx_n = '0;
        slot_n = (slot_q == SLOT_LAST) ? '0 : slot_q + SW'(1);
      end else begin
        bidx_n = bidx_q + BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced_q <= 1'b0;
      slot_q   <= '0;
      bidx_q   <= '0;
    end else begin
      synced_q <= synced_n;
      slot_q   <= slot_n;
      bidx_q   <= bidx_n;
    end
  end
endmodule

// File: rtl/tsh_tx_engine.sv
`timescale 1ns/1ps
module tsh_tx_engine import tsh_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       cfg_raw,
  input  logic       cfg_fill_flag,
  input  logic [7:0] cfg_idle,
  input  logic       fifo_empty,
  input  logic [8:0] fifo_data,
  output logic       fifo_pop,
  output logic       ser_out,
  output logic       ser_vld,
  output logic       udr_flag
);
  tx_st_e      st_q, st_n, dec_st, st_now;
  logic [7:0]  sh_q, sh_n, dec_byte, fill_byte;
  logic [2:0]  bcnt_q, bcnt_n, ones_q, ones_n;
  logic [15:0] crc_q, crc_n, crc_src;
  logic        eof_q, eof_n, udr_q, udr_n, so_q, so_n, sv_q;
  logic        dec_pop, dec_eof, dec_udr, dec_init, bit_now, stf_now, stuff, at_byte;

  assign fill_byte = (cfg_fill_flag && !cfg_raw) ? FLAG_BYTE : cfg_idle;
  assign at_byte   = (bcnt_q == 3'd0);
  assign stuff     = (ones_q == 3'(STUFF_RUN));

  // byte decision, taken when the first bit of the next byte is due
  always_comb begin
    dec_st   = ST_FILL;
    dec_byte = fill_byte;
    dec_pop  = 1'b0;
    dec_eof  = eof_q;
    dec_udr  = 1'b0;
    dec_init = 1'b0;
    case (st_q)
      ST_OPEN, ST_DATA: begin
        if (st_q == ST_DATA && eof_q) begin
          dec_st   = ST_FCS_LO;
          dec_byte = ~crc_q[7:0];
        end else if (!fifo_empty) begin
          dec_st   = ST_DATA;
          dec_byte = fifo_data[7:0];
          dec_eof  = fifo_data[8];
          dec_pop  = 1'b1;
        end else begin
          dec_st   = ST_ABORT;
          dec_byte = ABORT_BYTE;
          dec_udr  = 1'b1;
        end
      end
      ST_FCS_LO: begin
        dec_st   = ST_FCS_HI;
        dec_byte = ~crc_q[15:8];
      end
      ST_FCS_HI: begin
        dec_st   = ST_CLOSE;
        dec_byte = FLAG_BYTE;
      end
      default: begin
        if (!fifo_empty) begin
          if (cfg_raw) begin
            dec_st   = ST_RAW;
            dec_byte = fifo_data[7:0];
            dec_pop  = 1'b1;
          end else begin
            dec_st   = ST_OPEN;
            dec_byte = FLAG_BYTE;
            dec_init = 1'b1;
          end
        end
      end
    endcase
  end

  always_comb begin
    bit_now = at_byte ? dec_byte[0] : sh_q[0];
    st_now  = at_byte ? dec_st : st_q;
    stf_now = (st_now == ST_DATA) || (st_now == ST_FCS_LO) || (st_now == ST_FCS_HI);
    crc_src = (at_byte && dec_init) ? FCS_INIT : crc_q;
    st_n   = st_q;
    sh_n   = sh_q;
    bcnt_n = bcnt_q;
    ones_n = ones_q;
    crc_n  = crc_q;
    eof_n  = eof_q;
    udr_n  = udr_q;
    so_n   = so_q;
    if (take) begin
      if (stuff) begin
        so_n   = 1'b0;
        ones_n = 3'd0;
      end else begin
        so_n   = bit_now;
        bcnt_n = bcnt_q + 3'd1;
        ones_n = (stf_now && bit_now) ? ones_q + 3'd1 : 3'd0;
        crc_n  = (st_now == ST_DATA) ?
                 ({1'b0, crc_src[15:1]} ^ ((crc_src[0] ^ bit_now) ? FCS_POLY : 16'h0000)) :
                 crc_src;
        if (at_byte) begin
          st_n  = dec_st;
          sh_n  = {1'b0, dec_byte[7:1]};
          eof_n = dec_eof;
          udr_n = udr_q | dec_udr;
        end else begin
          sh_n = {1'b0, sh_q[7:1]};
        end
      end
    end
  end

  assign fifo_pop = take && !stuff && at_byte && dec_pop;
  assign ser_out  = so_q;
  assign ser_vld  = sv_q;
  assign udr_flag = udr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FILL;
      sh_q   <= '0;
      bcnt_q <= '0;
      ones_q <= '0;
      crc_q  <= FCS_INIT;
      eof_q  <= 1'b0;
      udr_q  <= 1'b0;
      so_q   <= 1'b0;
      sv_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      sh_q   <= sh_n;
      bcnt_q <= bcnt_n;
      ones_q <= ones_n;
      crc_q  <= crc_n;
      eof_q  <= eof_n;
      udr_q  <= udr_n;
      so_q   <= so_n;
      sv_q   <= take;
    end
  end
endmodule

// File: rtl/slot_hdlc_tx.sv
`timescale 1ns/1ps
module slot_hdlc_tx import tsh_pkg::*; #(
  parameter int SLOTS      = 24,
  parameter int FIFO_DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             wr_eof,
  input  logic             cfg_raw,
  input  logic             cfg_cont,
  input  logic             cfg_fill_flag,
  input  logic [7:0]       cfg_idle,
  input  logic [SLOTS-1:0] slot_en,
  input  logic             bit_en,
  input  logic             fsync,
  output logic             ser_out,
  output logic             ser_vld,
  output logic             ovf_flag,
  output logic             udr_flag
);
  localparam int ENTRY_W = 8 + 1;

  logic               fifo_full, fifo_empty, fifo_pop, wr_drop, take;
  logic [ENTRY_W-1:0] fifo_rdata;
  logic               ovf_q, ovf_n;

  tsh_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data ({wr_eof, wr_data}),
    .rd_pop  (fifo_pop),
    .cont    (cfg_cont && cfg_raw),
    .rd_data (fifo_rdata),
    .empty   (fifo_empty),
    .full    (fifo_full),
    .wr_drop (wr_drop)
  );

  tsh_slot_timer #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_tim (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .fsync   (fsync),
    .slot_en (slot_en),
    .take    (take)
  );

  tsh_tx_engine u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .take          (take),
    .cfg_raw       (cfg_raw),
    .cfg_fill_flag (cfg_fill_flag),
    .cfg_idle      (cfg_idle),
    .fifo_empty    (fifo_empty),
    .fifo_data     (fifo_rdata),
    .fifo_pop      (fifo_pop),
    .ser_out       (ser_out),
    .ser_vld       (ser_vld),
    .udr_flag      (udr_flag)
  );

  assign ovf_n    = ovf_q | wr_drop;
  assign ovf_flag = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_n;
  end
endmodule

// File: rtl/slot_hdlc_tx_chk.sv
`timescale 1ns/1ps
module slot_hdlc_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic fsync,
  input logic wr_en,
  input logic fifo_full,
  input logic fifo_empty,
  input logic ser_vld,
  input logic ovf_flag,
  input logic udr_flag
);
  logic seen_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 seen_sync_q <= 1'b0;
    else if (bit_en && fsync)   seen_sync_q <= 1'b1;
  end

  p_sync_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ser_vld |-> seen_sync_q);

  p_vld_on_data_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_vld |-> $past(bit_en && !fsync));

  p_drop_sets_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_full) |=> ovf_flag);

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  p_full_not_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  p_udr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    udr_flag |=> udr_flag);
endmodule

bind slot_hdlc_tx slot_hdlc_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .fsync      (fsync),
  .wr_en      (wr_en),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .ser_vld    (ser_vld),
  .ovf_flag   (ovf_flag),
  .udr_flag   (udr_flag)
);

// File: tb/tb_slot_hdlc_tx.sv
`timescale 1ns/1ps
module tb_slot_hdlc_tx;
  localparam int SLOTS = 24;
  localparam int FRAME_BITS = 193;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, wr_en, wr_eof, cfg_raw, cfg_cont, cfg_fill_flag, bit_en, fsync;
  logic [7:0] wr_data, cfg_idle;
  logic [SLOTS-1:0] slot_en;
  logic ser_out, ser_vld, ovf_flag, udr_flag;

  slot_hdlc_tx #(.SLOTS(SLOTS), .FIFO_DEPTH(64)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof),
    .cfg_raw(cfg_raw), .cfg_cont(cfg_cont), .cfg_fill_flag(cfg_fill_flag),
    .cfg_idle(cfg_idle), .slot_en(slot_en), .bit_en(bit_en), .fsync(fsync),
    .ser_out(ser_out), .ser_vld(ser_vld), .ovf_flag(ovf_flag), .udr_flag(udr_flag)
  );

  int    checks = 0, fails = 0;
  logic  exp_q[$];
  int    pos, sent = 0, lim = 0, ones_m;
  bit    synced_m, last_pred, ph;
  string cur_req = "R1";
  logic [15:0] crc_m;

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // line generator and scoreboard monitor, both at the falling edge
  initial begin
    bit_en = 1'b0; fsync = 1'b0; ph = 1'b0; last_pred = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
        chk(ser_vld === last_pred, "R1 R2 slot gating", int'(ser_vld), int'(last_pred));
        if (ser_vld && exp_q.size() > 0) begin
          logic e;
          e = exp_q.pop_front();
          chk(ser_out === e, cur_req, int'(ser_out), int'(e));
        end
      end
      last_pred = 1'b0;
      if (!ph && sent < lim && rst_n === 1'b1) begin
        bit_en = 1'b1;
        fsync  = (pos == 0);
        if (pos == 0) synced_m = 1'b1;
        last_pred = synced_m && (pos != 0) && slot_en[(pos - 1) / 8];
        if (last_pred) sent++;
        pos = (pos + 1) % FRAME_BITS;
      end else begin
        bit_en = 1'b0;
        fsync  = 1'b0;
      end
      ph = ~ph;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0; wr_eof = 1'b0; wr_data = 8'h00;
    cfg_raw = 1'b0; cfg_cont = 1'b0; cfg_fill_flag = 1'b1; cfg_idle = 8'h33;
    slot_en = '1;
    pos = 100; synced_m = 1'b0; ones_m = 0;
    exp_q.delete();
    lim = sent;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b, input logic e);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b; wr_eof = e;
    @(negedge clk);
    wr_en = 1'b0; wr_eof = 1'b0;
  endtask

  // expected-bit model: LSB first, zero after five ones when stf is set
  task automatic push_byte(input logic [7:0] b, input bit stf, input bit crc_on);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      if (ones_m == 5) begin exp_q.push_back(1'b0); ones_m = 0; end
      exp_q.push_back(b[i]);
      ones_m = (stf && b[i]) ? ones_m + 1 : 0;
      if (crc_on) begin
        fb = crc_m[0] ^ b[i];
        crc_m = crc_m >> 1;
        if (fb) crc_m = crc_m ^ 16'h8408;
      end
    end
  endtask

  task automatic push_frame(input logic [7:0] d[$]);
    logic [15:0] fcs;
    push_byte(8'h7E, 0, 0);
    crc_m = 16'hFFFF;
    foreach (d[i]) push_byte(d[i], 1, 1);
    fcs = ~crc_m;
    push_byte(fcs[7:0], 1, 0);
    push_byte(fcs[15:8], 1, 0);
    push_byte(8'h7E, 0, 0);
  endtask

  task automatic run_bits(input int n);
    lim = sent + n;
    wait (sent >= lim);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, cur_req, exp_q.size(), 0);
  endtask

  initial begin
    logic [7:0] fr[$];
    do_reset();
    // R1: reset state
    chk(ser_vld == 1'b0, "R1 vld", int'(ser_vld), 0);
    chk(ovf_flag == 1'b0, "R1 ovf", int'(ovf_flag), 0);
    chk(udr_flag == 1'b0, "R1 udr", int'(udr_flag), 0);
    // R7: flag timefill from an empty buffer
    cur_req = "R7 flag fill";
    push_byte(8'h7E, 0, 0); push_byte(8'h7E, 0, 0);
    run_bits(16);

    // R4 R5 R6: one frame with stuffing across bytes, flag fill after
    do_reset();
    cur_req = "R4 R5 R6 frame";
    fr = '{8'h7E, 8'hFF, 8'h1F, 8'hF8, 8'h00};
    foreach (fr[i]) wr(fr[i], i == fr.size() - 1);
    push_frame(fr);
    push_byte(8'h7E, 0, 0); push_byte(8'h7E, 0, 0);
    run_bits(exp_q.size());
    chk(udr_flag == 1'b0, "R8 no underrun on clean frame", int'(udr_flag), 0);

    // R2 R4 R7: sparse slot mask, two back-to-back frames, idle-byte fill
    do_reset();
    cur_req = "R2 R4 R5 R7 masked frames";
    slot_en = 24'h0F0F0A; cfg_fill_flag = 1'b0; cfg_idle = 8'h33;
    wr(8'h3C, 1);
    wr(8'hA1, 0); wr(8'hBE, 1);
    fr = '{8'h3C}; push_frame(fr);
    fr = '{8'hA1, 8'hBE}; push_frame(fr);
    push_byte(8'h33, 0, 0); push_byte(8'h33, 0, 0); push_byte(8'h33, 0, 0);
    run_bits(exp_q.size());

    // R8: buffer runs dry before the end-of-frame byte
    do_reset();
    cur_req = "R6 R8 underrun abort";
    wr(8'hFF, 0); wr(8'hFB, 0);
    push_byte(8'h7E, 0, 0);
    push_byte(8'hFF, 1, 0); push_byte(8'hFB, 1, 0);
    push_byte(8'hFF, 0, 0);
    push_byte(8'h7E, 0, 0);
    run_bits(exp_q.size());
    chk(udr_flag == 1'b1, "R8 underrun flag", int'(udr_flag), 1);

    // R9: transparent bytes, idle byte when empty even with flag fill selected
    do_reset();
    cur_req = "R9 transparent";
    cfg_raw = 1'b1; cfg_idle = 8'h99;
    fr = '{8'hFF, 8'hFF, 8'h7E, 8'h01};
    foreach (fr[i]) begin wr(fr[i], 1'b0); push_byte(fr[i], 0, 0); end
    push_byte(8'h99, 0, 0); push_byte(8'h99, 0, 0);
    run_bits(exp_q.size());

    // R10: continuous repeat, then release
    do_reset();
    cur_req = "R10 continuous";
    cfg_raw = 1'b1; cfg_cont = 1'b1; cfg_idle = 8'h99;
    fr = '{8'hA5, 8'h3C, 8'h0F};
    foreach (fr[i]) wr(fr[i], 1'b0);
    for (int r = 0; r < 2; r++) foreach (fr[i]) push_byte(fr[i], 0, 0);
    run_bits(exp_q.size());
    cfg_cont = 1'b0;
    repeat (2) @(negedge clk);
    cur_req = "R10 release drops bytes";
    push_byte(8'h99, 0, 0); push_byte(8'h99, 0, 0);
    run_bits(exp_q.size());

    // R3: fill all 64 entries, extra write dropped
    do_reset();
    cur_req = "R3 R9 full buffer";
    cfg_raw = 1'b1; cfg_idle = 8'h99;
    for (int i = 0; i < 64; i++) begin
      wr(8'(i * 3 + 1), 1'b0);
      push_byte(8'(i * 3 + 1), 0, 0);
    end
    chk(ovf_flag == 1'b0, "R3 no overflow at 64", int'(ovf_flag), 0);
    wr(8'hEE, 1'b0);
    chk(ovf_flag == 1'b1, "R3 overflow on 65th", int'(ovf_flag), 1);
    push_byte(8'h99, 0, 0); push_byte(8'h99, 0, 0);
    run_bits(exp_q.size());
    chk(ovf_flag == 1'b1, "R3 overflow sticky", int'(ovf_flag), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule